// File: doc/BRIEF.md
# Per-branch two-level direction predictor

This block guesses whether a conditional branch will be taken. Each static branch gets its own short record of recent outcomes, held in a tagged, set-associative history store. A group of low address bits picks both a set of that store and a private table of 2-bit saturating counters. The recorded outcomes then pick one counter inside that table, and the upper bit of that counter is the guess.

The block has two ports. The lookup port is purely combinational: a branch address goes in, and a direction and a flag that says whether the branch was found in the history store come out. The update port reports a resolved branch. On the next clock edge the block pushes the outcome into that branch's history, trains the counter that served its prediction, and claims the least recently used way when the branch had no entry. Addresses are in instruction units, so bit 0 is the lowest bit of the branch's index. The full-size configuration uses `SET_BITS = 9`. The default is smaller so that the counter storage stays modest.

Top module: `pa_branch_predictor`

## Requirements
- R1: After reset no branch is held: every lookup reports a miss and predicts not-taken, because all counters start at value 1 (weak not-taken).
- R2: The lookup outputs follow the inputs in the same cycle. With `lk_valid` low both outputs are 0. Otherwise `lk_taken` is bit 1 of the counter chosen by set = address bits [SET_BITS-1:0] and by the branch's history.
- R3: An update moves the counter that served the prediction up by one on taken and down by one on not-taken. It holds at 3 and at 0.
- R4: An update shifts the branch history left by one. The new outcome enters bit 0 (1 = taken) and the oldest of the HIST bits is dropped.
- R5: A lookup hits only when a valid way of its set stores the address bits above the set field. Another address in the same set misses.
- R6: A lookup that misses uses the all-zero history of its set's table.
- R7: An update that misses takes the least recently used way of its set. The history there starts cleared and then receives the shift, so the counter at history 0 is trained. The branch that was evicted then misses.
- R8: Recency is refreshed by every lookup that hits and by every update. In a cycle that has both, the update counts as the later one.
- R9: When a lookup and an update name the same branch in one cycle, the lookup returns the state from before that update.
- R10: Branches that share a set also share its counter table, so training through one history value changes the prediction for any branch in that set with the same history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | ADDR_W | Branch address being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hit | output | 1 | Branch found in the history store |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench checks eviction order directly. Five branches go into one set, so a design that evicted the wrong way would lose a recently used branch and report it as a miss. A second sequence shows that a lookup hit rescues the oldest way. A design that refreshed recency only on updates would drop that branch. A same-cycle lookup and update of one branch catches a design that forwards the new state. Saturation runs in both directions catch counter wrap, and a train-then-probe test with a fresh tag catches a miss path that reads anything other than history zero. A long stretch of random traffic over a few crowded sets mixes aliasing, eviction and history patterns together.

// File: rtl/pa_branch_predictor.sv
module pa_branch_predictor #(
  parameter int ADDR_W   = 16,
  parameter int SET_BITS = 5,
  parameter int WAYS     = 4,
  parameter int HIST     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  output logic              lk_hit,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_BITS;
  localparam int ENT    = SETS * WAYS;
  localparam int ENT_W  = SET_BITS + WAY_W;
  localparam int PIDX_W = SET_BITS + HIST;
  localparam int PHT_N  = 1 << PIDX_W;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic             vld    [ENT];
  logic [TAG_W-1:0] tag_q  [ENT];
  logic [HIST-1:0]  hist_q [ENT];
  logic [WAY_W-1:0] age_q  [ENT];
  logic [1:0]       pht    [PHT_N];

  function automatic logic [ENT_W-1:0] ent(input logic [SET_BITS-1:0] s, input int w);
    return {s, WAY_W'(w)};
  endfunction

  logic [SET_BITS-1:0] lk_set, up_set;
  logic [TAG_W-1:0]    lk_tag, up_tag;
  assign lk_set = lk_addr[SET_BITS-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:SET_BITS];
  assign up_set = up_addr[SET_BITS-1:0];
  assign up_tag = up_addr[ADDR_W-1:SET_BITS];

  logic             lk_hit_w, up_hit_w;
  logic [WAY_W-1:0] lk_way, up_hway, victim, up_way;

  always_comb begin
    lk_hit_w = 1'b0;
    lk_way   = '0;
    up_hit_w = 1'b0;
    up_hway  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[ent(lk_set, w)] && tag_q[ent(lk_set, w)] == lk_tag) begin
        lk_hit_w = 1'b1;
        lk_way   = WAY_W'(w);
      end
      if (vld[ent(up_set, w)] && tag_q[ent(up_set, w)] == up_tag) begin
        up_hit_w = 1'b1;
        up_hway  = WAY_W'(w);
      end
    end
  end

  logic [HIST-1:0]   lk_hist;
  logic [PIDX_W-1:0] lk_pidx;
  assign lk_hist  = lk_hit_w ? hist_q[ent(lk_set, int'(lk_way))] : '0;
  assign lk_pidx  = {lk_set, lk_hist};
  assign lk_taken = lk_valid & pht[lk_pidx][1];
  assign lk_hit   = lk_valid & lk_hit_w;

  logic lk_touch;
  assign lk_touch = lk_valid & lk_hit_w;

  logic [WAY_W-1:0] lk_age_nx [WAYS];
  logic [WAY_W-1:0] up_base   [WAYS];
  logic [WAY_W-1:0] up_age_nx [WAYS];

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == lk_way)
        lk_age_nx[w] = '0;
      else if (age_q[ent(lk_set, w)] < age_q[ent(lk_set, int'(lk_way))])
        lk_age_nx[w] = age_q[ent(lk_set, w)] + 1'b1;
      else
        lk_age_nx[w] = age_q[ent(lk_set, w)];
      up_base[w] = (lk_touch && lk_set == up_set) ? lk_age_nx[w] : age_q[ent(up_set, w)];
      if (up_base[w] == OLDEST) victim = WAY_W'(w);
    end
  end

  assign up_way = up_hit_w ? up_hway : victim;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == up_way)
        up_age_nx[w] = '0;
      else if (up_base[w] < up_base[up_way])
        up_age_nx[w] = up_base[w] + 1'b1;
      else
        up_age_nx[w] = up_base[w];
    end
  end

  logic [ENT_W-1:0]  up_ent;
  logic [HIST-1:0]   up_old_hist, up_hist_nx;
  logic [PIDX_W-1:0] up_pidx;
  logic [1:0]        up_ctr_old, up_ctr_nx;

  assign up_ent      = {up_set, up_way};
  assign up_old_hist = up_hit_w ? hist_q[up_ent] : '0;
  assign up_hist_nx  = {up_old_hist[HIST-2:0], up_taken};
  assign up_pidx     = {up_set, up_old_hist};
  assign up_ctr_old  = pht[up_pidx];
  assign up_ctr_nx   = up_taken ? ((up_ctr_old == 2'd3) ? 2'd3 : up_ctr_old + 2'd1)
                                : ((up_ctr_old == 2'd0) ? 2'd0 : up_ctr_old - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENT; i++) begin
        vld[i]    <= 1'b0;
        tag_q[i]  <= '0;
        hist_q[i] <= '0;
        age_q[i]  <= WAY_W'(i % WAYS);
      end
      for (int p = 0; p < PHT_N; p++) pht[p] <= 2'd1;
    end else begin
      if (lk_touch)
        for (int w = 0; w < WAYS; w++) age_q[ent(lk_set, w)] <= lk_age_nx[w];
      if (up_valid) begin
        for (int w = 0; w < WAYS; w++) age_q[ent(up_set, w)] <= up_age_nx[w];
        vld[up_ent]    <= 1'b1;
        tag_q[up_ent]  <= up_tag;
        hist_q[up_ent] <= up_hist_nx;
        pht[up_pidx]   <= up_ctr_nx;
      end
    end
  end
endmodule

// File: rtl/pa_bp_checker.sv
module pa_bp_checker #(
  parameter int SET_BITS = 5,
  parameter int WAYS     = 4,
  parameter int HIST     = 6,
  parameter int TAG_W    = 11
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           lk_valid,
  input logic                           lk_hit,
  input logic                           lk_taken,
  input logic                           up_valid,
  input logic                           up_taken,
  input logic [SET_BITS-1:0]            up_set,
  input logic [SET_BITS+$clog2(WAYS)-1:0] up_ent,
  input logic [HIST-1:0]                up_old_hist,
  input logic [SET_BITS+HIST-1:0]       up_pidx,
  input logic [1:0]                     up_ctr_old,
  input logic                           vld    [(1<<SET_BITS)*WAYS],
  input logic [HIST-1:0]                hist_q [(1<<SET_BITS)*WAYS],
  input logic [$clog2(WAYS)-1:0]        age_q  [(1<<SET_BITS)*WAYS],
  input logic [1:0]                     pht    [1<<(SET_BITS+HIST)]
);
  localparam int WAY_W = $clog2(WAYS);

  logic [SET_BITS-1:0] chk_set_q;
  always_ff @(posedge clk) chk_set_q <= up_set;

  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[age_q[{chk_set_q, WAY_W'(w)}]] = 1'b1;
  end

  a_r1_reset_miss: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lk_hit);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_taken));

  a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_taken) |=>
      pht[$past(up_pidx)] == (($past(up_ctr_old) == 2'd3) ? 2'd3 : 2'($past(up_ctr_old) + 2'd1)));

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken) |=>
      pht[$past(up_pidx)] == (($past(up_ctr_old) == 2'd0) ? 2'd0 : 2'($past(up_ctr_old) - 2'd1)));

  a_r4_history_shift: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> hist_q[$past(up_ent)] == {$past(up_old_hist[HIST-2:0]), $past(up_taken)});

  a_r7_entry_valid: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> vld[$past(up_ent)]);

  a_r8_ages_distinct: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> $countones(age_seen) == WAYS);
endmodule

bind pa_branch_predictor pa_bp_checker #(
  .SET_BITS(SET_BITS), .WAYS(WAYS), .HIST(HIST), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/pa_branch_predictor_test.sv
module pa_branch_predictor_test;
  localparam int PERIOD = 10;
  localparam int SB = 5;
  localparam int NW = 4;
  localparam int HB = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, up_valid = 1'b0, up_taken = 1'b0;
  logic [15:0] lk_addr = '0, up_addr = '0;
  logic        lk_taken, lk_hit;

  pa_branch_predictor uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_taken(lk_taken), .lk_hit(lk_hit),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct { bit taken; bit hit; string rq; } exp_t;
  exp_t q[$];
  event smp;
  int checks = 0, errors = 0;
  bit done = 0;

  int lru [1<<SB][$];
  int mh [int];
  int mc [int];

  function automatic int hkey(int s, int t); return s * 65536 + t; endfunction
  function automatic int ctr(int s, int h);
    return mc.exists(s * 64 + h) ? mc[s * 64 + h] : 1;
  endfunction
  function automatic int find(int s, int t);
    foreach (lru[s][i]) if (lru[s][i] == t) return i;
    return -1;
  endfunction
  function automatic void to_front(int s, int i);
    int t = lru[s][i];
    lru[s].delete(i);
    lru[s].push_front(t);
  endfunction

  task automatic cyc(input bit lv, input logic [15:0] la, input bit uv,
                     input logic [15:0] ua, input bit ut, input string rq);
    exp_t e;
    int s, t, i, h, c;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut;
    e.taken = 0; e.hit = 0; e.rq = rq;
    if (lv) begin
      s = int'(la[SB-1:0]); t = int'(la[15:SB]);
      i = find(s, t);
      h = (i >= 0) ? mh[hkey(s, t)] : 0;
      e.taken = ctr(s, h) >= 2;
      e.hit = i >= 0;
      if (i >= 0) to_front(s, i);
    end
    if (uv) begin
      s = int'(ua[SB-1:0]); t = int'(ua[15:SB]);
      i = find(s, t);
      if (i >= 0) begin
        to_front(s, i);
      end else begin
        if (lru[s].size() == NW) mh.delete(hkey(s, lru[s].pop_back()));
        lru[s].push_front(t);
        mh[hkey(s, t)] = 0;
      end
      h = mh[hkey(s, t)];
      c = ctr(s, h);
      mc[s * 64 + h] = ut ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
      mh[hkey(s, t)] = ((h << 1) | int'(ut)) & 63;
    end
    q.push_back(e);
    #(PERIOD/4);
    ->smp;
  endtask

  initial begin
    exp_t e;
    forever begin
      @(smp);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lk_taken !== e.taken || lk_hit !== e.hit) begin
          errors++;
          $display("FAIL %s taken/hit actual %b/%b expected %b/%b", e.rq,
                   lk_taken, lk_hit, e.taken, e.hit);
        end
      end
    end
  end

  function automatic logic [15:0] ad(int tag, int set);
    return {11'(tag), 5'(set)};
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc(1, ad(3, 1), 0, 0, 0, "R1");
    cyc(1, ad(9, 30), 0, 0, 0, "R1");
    cyc(0, ad(3, 1), 0, 0, 0, "R2");
    // R3: saturation upward then downward
    for (int k = 0; k < 10; k++) begin
      cyc(0, 0, 1, ad(5, 2), 1, "R3");
      cyc(1, ad(5, 2), 0, 0, 0, "R3");
    end
    for (int k = 0; k < 10; k++) begin
      cyc(0, 0, 1, ad(5, 2), 0, "R3");
      cyc(1, ad(5, 2), 0, 0, 0, "R3");
    end
    // R4: alternating pattern learned through history
    for (int k = 0; k < 24; k++) begin
      cyc(0, 0, 1, ad(6, 3), k[0], "R4");
      cyc(1, ad(6, 3), 0, 0, 0, "R4");
    end
    // R5: same set, other tag misses
    cyc(1, ad(7, 3), 0, 0, 0, "R5");
    cyc(1, ad(6, 3), 0, 0, 0, "R5");
    // R6: miss path reads history zero after training it
    cyc(0, 0, 1, ad(1, 8), 1, "R6");
    cyc(0, 0, 1, ad(2, 8), 1, "R6");
    cyc(1, ad(9, 8), 0, 0, 0, "R6");
    // R7: five branches in one set evict the oldest
    for (int k = 1; k <= 5; k++) cyc(0, 0, 1, ad(k, 12), 0, "R7");
    for (int k = 1; k <= 5; k++) cyc(1, ad(k, 12), 0, 0, 0, "R7");
    // R8: lookup hit rescues the oldest way
    for (int k = 1; k <= 4; k++) cyc(0, 0, 1, ad(k, 13), 1, "R8");
    cyc(1, ad(1, 13), 0, 0, 0, "R8");
    cyc(0, 0, 1, ad(5, 13), 1, "R8");
    for (int k = 1; k <= 5; k++) cyc(1, ad(k, 13), 0, 0, 0, "R8");
    // R9: same-cycle lookup and update of one branch
    for (int k = 0; k < 4; k++) cyc(1, ad(4, 20), 1, ad(4, 20), 1, "R9");
    cyc(1, ad(4, 20), 0, 0, 0, "R9");
    // R10: aliasing through a shared counter table
    cyc(0, 0, 1, ad(1, 22), 1, "R10");
    cyc(0, 0, 1, ad(1, 22), 1, "R10");
    cyc(0, 0, 1, ad(2, 22), 1, "R10");
    cyc(1, ad(3, 22), 0, 0, 0, "R10");
    cyc(0, 0, 1, ad(2, 22), 0, "R10");
    cyc(1, ad(2, 22), 0, 0, 0, "R10");
    // mixed random traffic on crowded sets
    for (int k = 0; k < 3000; k++) begin
      int s1 = 24 + int'($urandom_range(0, 2));
      int s2 = 24 + int'($urandom_range(0, 2));
      cyc(1'($urandom_range(0, 3) != 0), ad(int'($urandom_range(0, 6)), s1),
          1'($urandom_range(0, 1)), ad(int'($urandom_range(0, 6)), s2),
          1'($urandom_range(0, 2) != 0), "R2");
    end
    cyc(0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule